// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Feedback Divider

This block is the digital feedback divider of a frequency synthesizer. The fast clock `clk_i` stands in for the oscillator output. The block splits that clock into division cycles. It marks the last clock of each cycle with a one-clock pulse on `div_pulse_o`. Each cycle lasts either N or N+1 clocks. A modulo-D phase accumulator picks the length of each cycle. It adds a numerator F once per cycle and asks for the longer modulus whenever its sum reaches D. Over D cycles, F of them are long, so the average ratio is N + F/D.

A host sets N, F and D through a simple write port. The new values are held in shadow registers. They take effect only where one division cycle ends and the next begins, so changing channel needs no other action. A second, integer-only divider turns reference strobes (`ref_tick_i`) into comparison-rate pulses on `ref_pulse_o`, once every R strobes. The phase detector, charge pump, loop filter and oscillator lie outside this block.

Top module: `fracn_synth_div`

## Requirements
- R1: Every division cycle lasts either N or N+1 clocks. `mod_sel_o` is high during a cycle if and only if that cycle uses N+1, so each pulse-to-pulse spacing equals N plus the `mod_sel_o` value seen in the pulse cycle.
- R2: With N, F and D held constant, any D consecutive division cycles contain exactly F cycles of length N+1. With F=1 and D=10, one cycle in ten is long, which gives an average ratio of N+0.1.
- R3: A write with `wr_en_i` high stores the low bits of `wr_data_i` into one setting, chosen by `wr_addr_i`: 0 = integer N, 1 = numerator F, 2 = denominator D, 3 = reference ratio R. The new settings govern the division cycles that follow, with no further action from the host.
- R4: N, F, D and the mode select change only at the clock edge that ends a division cycle. A cycle in progress finishes with the values it started with, so no cycle length mixes old and new settings.
- R5: With F=0, raising N by one lengthens every division cycle by exactly one clock.
- R6: A written N of 0 or 1 behaves as N=2.
- R7: With F=0, every cycle lasts N clocks and `mod_sel_o` stays low.
- R8: While `rst_ni` is low, all outputs are low. Reset loads N=8, F=0, D=10 and R=1. `div_pulse_o` first goes high N-1 clock edges after reset is released, and cycles then last 8 clocks.
- R9: `ref_pulse_o` is high for one clock, in the cycle after every R-th clock that has `ref_tick_i` high, and it is low at all other times. With R=1, every strobe produces a pulse. R=0 behaves as R=1. A new R takes effect after the next reference pulse.
- R10: D=0 behaves as D=1. A numerator F at or above the effective D behaves as D-1.
- R11: `div_pulse_o` is never high on two clocks in a row. `mod_sel_o` changes only at the edge that ends a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Setting write strobe |
| wr_addr_i | input | 2 | Setting select (0 N, 1 F, 2 D, 3 R) |
| wr_data_i | input | DATA_W | Write value, low bits used |
| ref_tick_i | input | 1 | One strobe per reference clock edge |
| div_pulse_o | output | 1 | High on the last clock of each division cycle |
| mod_sel_o | output | 1 | High during a cycle that uses N+1 |
| ref_pulse_o | output | 1 | Comparison-rate pulse from the reference divider |

## Verification
The hardest case to reach from the ports is a write that lands partway through a division cycle, or on the very clock that ends one. The accumulator also has to be caught mid-sequence, after D has shrunk below its stored value. Random stimulus writes new N, F and D with arbitrary phase against the running divider. After each write, the bench skips one boundary and then checks every sliding window of D cycles for exactly F long cycles. Separate directed runs drop a new N in at a random offset inside a cycle and require a clean switch from old spacing to new spacing.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int unsigned N_FLOOR = 2;

  typedef enum logic [1:0] {
    SEL_N = 2'd0,
    SEL_F = 2'd1,
    SEL_D = 2'd2,
    SEL_R = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/fracn_cfg_regs.sv
module fracn_cfg_regs
  import fracn_pkg::*;
#(
  parameter int unsigned N_W    = 8,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned R_W    = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_DEF  = 8,
  parameter int unsigned D_DEF  = 10,
  parameter int unsigned R_DEF  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_W-1:0]    n_o,
  output logic [FRAC_W-1:0] f_o,
  output logic [FRAC_W-1:0] d_o,
  output logic [R_W-1:0]    r_o
);

  logic [N_W-1:0]    n_sh;
  logic [FRAC_W-1:0] f_sh, d_sh;
  logic [R_W-1:0]    r_sh;
  logic              unused_data;

  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_sh <= N_W'(N_DEF);
      f_sh <= '0;
      d_sh <= FRAC_W'(D_DEF);
      r_sh <= R_W'(R_DEF);
    end else if (wr_en_i) begin
      case (cfg_sel_e'(wr_addr_i))
        SEL_N:   n_sh <= wr_data_i[N_W-1:0];
        SEL_F:   f_sh <= wr_data_i[FRAC_W-1:0];
        SEL_D:   d_sh <= wr_data_i[FRAC_W-1:0];
        default: r_sh <= wr_data_i[R_W-1:0];
      endcase
    end
  end

  // Legalise settings so downstream logic never sees a degenerate value
  always_comb begin
    n_o = (n_sh < N_W'(N_FLOOR)) ? N_W'(N_FLOOR) : n_sh;
    d_o = (d_sh == '0) ? FRAC_W'(1) : d_sh;
    f_o = (f_sh >= d_o) ? d_o - FRAC_W'(1) : f_sh;
    r_o = (r_sh == '0) ? R_W'(1) : r_sh;
  end

endmodule

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] f_i,
  input  logic [FRAC_W-1:0] d_i,
  output logic              wrap_o
);

  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  base, sum, acc_nx;
  logic              unused_top;

  // A shrunken D can leave acc_q out of range; restart the phase at zero
  always_comb begin
    base   = (acc_q >= d_i) ? '0 : {1'b0, acc_q};
    sum    = base + {1'b0, f_i};
    wrap_o = (sum >= {1'b0, d_i});
    acc_nx = wrap_o ? sum - {1'b0, d_i} : sum;
  end

  assign unused_top = acc_nx[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= acc_nx[FRAC_W-1:0];
  end

endmodule

// File: rtl/fracn_dm_counter.sv
module fracn_dm_counter
  import fracn_pkg::*;
#(
  parameter int unsigned N_W   = 8,
  parameter int unsigned N_DEF = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_ld_i,
  input  logic           mode_ld_i,
  output logic           pulse_o,
  output logic [N_W-1:0] n_act_o,
  output logic           mode_o
);

  localparam int unsigned CNT_W = N_W + 1;
  localparam int unsigned N_RST = (N_DEF < N_FLOOR) ? N_FLOOR : N_DEF;

  logic [CNT_W-1:0] cnt_q, last;
  logic [N_W-1:0]   n_act_q;
  logic             mode_q;

  assign last    = CNT_W'(n_act_q) + CNT_W'(mode_q) - CNT_W'(1);
  assign pulse_o = (cnt_q == last);
  assign n_act_o = n_act_q;
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      n_act_q <= N_W'(N_RST);
      mode_q  <= 1'b0;
    end else if (pulse_o) begin
      cnt_q   <= '0;
      n_act_q <= n_ld_i;
      mode_q  <= mode_ld_i;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/fracn_ref_div.sv
module fracn_ref_div #(
  parameter int unsigned R_W   = 8,
  parameter int unsigned R_DEF = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [R_W-1:0] r_i,
  output logic           pulse_o,
  output logic [R_W-1:0] r_act_o
);

  localparam int unsigned R_RST = (R_DEF == 0) ? 1 : R_DEF;

  logic [R_W-1:0] cnt_q, r_act_q;
  logic           pulse_q;
  logic           at_end;

  assign at_end  = (cnt_q == r_act_q - R_W'(1));
  assign pulse_o = pulse_q;
  assign r_act_o = r_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      r_act_q <= R_W'(R_RST);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick_i && at_end;
      if (tick_i) begin
        if (at_end) begin
          cnt_q   <= '0;
          r_act_q <= r_i;
        end else begin
          cnt_q   <= cnt_q + R_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fracn_synth_div.sv
module fracn_synth_div
  import fracn_pkg::*;
#(
  parameter int unsigned N_W    = 8,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned R_W    = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_DEF  = 8,
  parameter int unsigned D_DEF  = 10,
  parameter int unsigned R_DEF  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ref_tick_i,
  output logic              div_pulse_o,
  output logic              mod_sel_o,
  output logic              ref_pulse_o
);

  logic [N_W-1:0]    n_eff, n_act;
  logic [FRAC_W-1:0] f_eff, d_eff;
  logic [R_W-1:0]    r_eff, r_act;
  logic              mode_next, div_pulse, mode_act;

  fracn_cfg_regs #(
    .N_W(N_W), .FRAC_W(FRAC_W), .R_W(R_W), .DATA_W(DATA_W),
    .N_DEF(N_DEF), .D_DEF(D_DEF), .R_DEF(R_DEF)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .n_o(n_eff), .f_o(f_eff), .d_o(d_eff), .r_o(r_eff)
  );

  fracn_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(div_pulse),
    .f_i(f_eff), .d_i(d_eff), .wrap_o(mode_next)
  );

  fracn_dm_counter #(.N_W(N_W), .N_DEF(N_DEF)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .n_ld_i(n_eff), .mode_ld_i(mode_next),
    .pulse_o(div_pulse), .n_act_o(n_act), .mode_o(mode_act)
  );

  fracn_ref_div #(.R_W(R_W), .R_DEF(R_DEF)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick_i),
    .r_i(r_eff), .pulse_o(ref_pulse_o), .r_act_o(r_act)
  );

  assign div_pulse_o = div_pulse;
  assign mod_sel_o   = mode_act;

endmodule

// File: rtl/fracn_synth_div_chk.sv
module fracn_synth_div_chk #(
  parameter int unsigned N_W    = 8,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned R_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_pulse_i,
  input logic              mod_sel_i,
  input logic [N_W-1:0]    n_act_i,
  input logic [FRAC_W-1:0] f_eff_i,
  input logic              ref_tick_i,
  input logic [R_W-1:0]    r_act_i,
  input logic              ref_pulse_i
);

  logic [N_W+1:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (div_pulse_i) begin
      gap_q  <= (N_W+2)'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + (N_W+2)'(1);
    end
  end

  p_gap_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && div_pulse_i) |-> (gap_q == (N_W+2)'(n_act_i) + (N_W+2)'(mod_sel_i)));

  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_pulse_i |=> ($stable(n_act_i) && $stable(mod_sel_i)));

  p_n_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_act_i >= N_W'(2));

  p_int_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_i && f_eff_i == '0) |=> !mod_sel_i);

  p_ref_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && r_act_i == R_W'(1)) |=> ref_pulse_i);

  p_ref_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> !ref_pulse_i);

  p_pulse_narrow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_i |=> !div_pulse_i);

endmodule

bind fracn_synth_div fracn_synth_div_chk #(
  .N_W(N_W), .FRAC_W(FRAC_W), .R_W(R_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .div_pulse_i(div_pulse), .mod_sel_i(mode_act), .n_act_i(n_act),
  .f_eff_i(f_eff), .ref_tick_i(ref_tick_i), .r_act_i(r_act),
  .ref_pulse_i(ref_pulse_o)
);

// File: tb/fracn_synth_div_tb.sv
module fracn_synth_div_tb;

  localparam int N_W = 8, FRAC_W = 8, R_W = 8, DATA_W = 16;
  localparam int N_DEF = 8, D_DEF = 10, R_DEF = 1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ref_tick = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic div_pulse, mod_sel, ref_pulse;

  always #4 clk = ~clk;

  fracn_synth_div #(
    .N_W(N_W), .FRAC_W(FRAC_W), .R_W(R_W), .DATA_W(DATA_W),
    .N_DEF(N_DEF), .D_DEF(D_DEF), .R_DEF(R_DEF)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ref_tick_i(ref_tick), .div_pulse_o(div_pulse),
    .mod_sel_o(mod_sel), .ref_pulse_o(ref_pulse)
  );

  int errors = 0, checks = 0;
  int cyc = 0, last_cyc = 0, ng = 0, npulse = 0;
  bit have_last = 1'b0, prev_pulse = 1'b0, prev_mod = 1'b0;
  int viol_narrow = 0, viol_mode = 0;
  int gaps [256];
  bit mods [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_model(input int n);
    return (n < 2) ? 2 : n;
  endfunction
  function automatic int d_model(input int d);
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int f_model(input int f, input int d);
    return (f >= d_model(d)) ? d_model(d) - 1 : f;
  endfunction

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (div_pulse && prev_pulse) viol_narrow++;
      if (mod_sel !== prev_mod && !prev_pulse) viol_mode++;
      if (div_pulse) begin
        npulse++;
        if (have_last && ng < 256) begin
          gaps[ng] = cyc - last_cyc;
          mods[ng] = mod_sel;
          ng++;
        end
        last_cyc  = cyc;
        have_last = 1'b1;
      end
      prev_pulse = div_pulse;
      prev_mod   = mod_sel;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[DATA_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    int s = npulse;
    int t = 0;
    while (npulse == s && t < 4000) begin @(posedge clk); t++; end
  endtask

  task automatic wait_gaps(input int k);
    int t = 0;
    while (ng < k && t < 40000) begin @(posedge clk); t++; end
  endtask

  // Skip one boundary so new settings are loaded, then capture spacings
  task automatic collect(input int k);
    wait_pulse();
    have_last = 1'b0;
    ng = 0;
    wait_gaps(k);
  endtask

  task automatic measure(input int n, input int f, input int d, input string tag);
    int ne = n_model(n), de = d_model(d), fe = f_model(f, d);
    int k = 2 * de + 4;
    int bad = 0, badw = 0;
    wr(0, n); wr(1, f); wr(2, d);
    collect(k);
    for (int i = 0; i < k; i++)
      if (gaps[i] != ne + int'(mods[i]) || i >= ng) bad++;
    chk(bad == 0, $sformatf("R1/R3/%s spacing N=%0d", tag, ne), bad, 0);
    for (int s = 0; s + de <= k; s++) begin
      int ones = 0;
      for (int j = 0; j < de; j++) ones += int'(mods[s + j]);
      if (ones != fe) badw++;
    end
    chk(badw == 0, $sformatf("R2/%s long cycles per %0d F=%0d", tag, de, fe), badw, 0);
  endtask

  task automatic strobe();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic ref_run(input int r);
    int re = (r == 0) ? 1 : r;
    int bad = 0, t = 0;
    wr(3, r);
    do begin strobe(); t++; end while (!ref_pulse && t < 600);
    for (int rep = 0; rep < 3; rep++)
      for (int j = 1; j <= re; j++) begin
        strobe();
        if (ref_pulse != (j == re)) bad++;
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          if (ref_pulse) bad++;
        end
      end
    chk(bad == 0, $sformatf("R9 ref ratio R=%0d", re), bad, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k;
    void'($urandom(32'd2024));

    // R8 reset state
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R8 div_pulse_o in reset", int'(div_pulse), 0);
    chk(mod_sel == 1'b0, "R8 mod_sel_o in reset", int'(mod_sel), 0);
    chk(ref_pulse == 1'b0, "R8 ref_pulse_o in reset", int'(ref_pulse), 0);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!div_pulse && k < 100);
    chk(k == N_DEF - 1, "R8 first pulse edge count", k, N_DEF - 1);
    strobe();
    chk(ref_pulse == 1'b1, "R8/R9 default ref pass-through", int'(ref_pulse), 1);
    collect(4);
    k = 0;
    for (int i = 0; i < 4; i++) if (gaps[i] != N_DEF || mods[i]) k++;
    chk(k == 0, "R8 default spacing", k, 0);

    // Directed corners
    measure(7, 1, 10, "R2");
    measure(1, 0, 10, "R6");
    measure(0, 3, 7, "R6");
    measure(9, 0, 10, "R7");
    measure(6, 12, 10, "R10");
    measure(5, 4, 0, "R10");
    measure(3, 5, 9, "R2");

    // R5 one-step resolution
    measure(6, 0, 5, "R5");
    k = gaps[0];
    measure(7, 0, 5, "R5");
    chk(gaps[0] == k + 1, "R5 step of one clock", gaps[0], k + 1);

    // R4 write at arbitrary phase: clean old-to-new switch
    begin
      int bad = 0;
      bit seen_new = 1'b0;
      wr(0, 5); wr(1, 0); wr(2, 10);
      wait_pulse(); wait_pulse();
      have_last = 1'b0; ng = 0;
      wait_pulse();
      repeat ($urandom_range(0, 4)) @(negedge clk);
      wr(0, 9);
      wait_gaps(8);
      for (int i = 0; i < 8; i++) begin
        if (gaps[i] == 9) seen_new = 1'b1;
        else if (gaps[i] != 5 || seen_new) bad++;
      end
      chk(bad == 0 && gaps[7] == 9, "R4 no mixed cycle", gaps[7], 9);
    end

    // Constrained random settings
    for (int it = 0; it < 12; it++) begin
      int rn = $urandom_range(0, 20);
      int rd = $urandom_range(0, 16);
      int rf = $urandom_range(0, rd + 2);
      measure(rn, rf, rd, "R3");
    end

    // Reference divider
    ref_run(3);
    ref_run(1);
    ref_run(0);
    ref_run(5);
    ref_run($urandom_range(2, 9));

    chk(viol_narrow == 0, "R11 pulse one clock wide", viol_narrow, 0);
    chk(viol_mode == 0, "R11 mode changes only at boundary", viol_mode, 0);
    finish_run();
  end

endmodule